// File: doc/BRIEF.md
# Sector ECC Status Evaluator

This block decides what to do with a page that a NAND flash controller has just read into its buffer. It is started once per page. It first waits for the controller's operation-complete event, and it treats a flash timeout seen at that moment as fatal. It then reads only the 32-bit error-status words that cover the page's sectors, one word per cycle, and looks at the 4-bit error count of each sector. If every count in range is correctable, the page is good.

When a sector reports the uncorrectable code, the block does not give up at once. An erased page fails the hardware check, so the block scans the page's main-area bytes from a valid/ready byte stream. A page that is entirely 0xFF is reported as blank, and the remaining sectors are not examined. Any other byte makes the error fatal. Each evaluation ends with a one-cycle done pulse and exactly one result flag. A good or blank outcome also requests a write-one-to-clear of the event value that was observed.

Top module: `ecc_sector_eval`

## Requirements
- R1: `pg_sel` selects the page size. 2'b01 means 2048 bytes (4 sectors), 2'b10 means 4096 bytes (8 sectors), and 2'b00 or 2'b11 means 512 bytes (1 sector). A sector is 512 bytes.
- R2: The sector range is first = (`buf_num` × sectors-per-page) mod SECTORS and last = first + sectors-per-page − 1. An uncorrectable count in any sector outside this range has no effect on the result.
- R3: Sector n lives in status word n/4, in the byte at bits [31−8·(n mod 4) −: 8], so lower sector numbers sit in more significant bytes. Its error count is the low nibble of that byte, and the high nibble is ignored. A count of 15 means uncorrectable.
- R4: Status words first/4 through last/4 are fetched in ascending order, one per cycle. During each fetch cycle `stat_rd` is high, `word_addr` holds the index, and `word_data` is taken in that same cycle. `stat_rd` is low in all other cycles.
- R5: After a `start` pulse, the block samples `evt_status` every cycle from the next cycle on. It holds until the operation-complete bit (OPC_BIT, default bit 0) is set, and latches the value seen in that cycle. Fetching starts in the following cycle.
- R6: If the timeout bit (TOUT_BIT, default bit 1) is set in the latched value, the next cycle shows `done` with `res_timeout`. `timeout_fatal` then stays set, and no status word is fetched.
- R7: If no sector in range is uncorrectable, `done` with `res_good` appears in the cycle after the last fetch.
- R8: The first uncorrectable sector starts a blank scan, with `byte_ready` high from the next cycle. A byte is consumed when `byte_valid` and `byte_ready` are both high. If all sectors-per-page × 512 bytes are 0xFF, `done` with `res_blank` follows the last byte, and no later sector is examined.
- R9: A consumed byte other than 0xFF ends the scan at that byte, including when it is the last byte. The next cycle shows `done` with `res_ecc`, `byte_ready` low, and `ecc_fatal` set and held.
- R10: On a good or blank result, `evt_clr_we` pulses together with `done`, and `evt_clr_val` carries the latched event value. A fatal result does not pulse `evt_clr_we`.
- R11: `done` lasts one cycle and comes with exactly one result flag. No result flag is high without `done`.
- R12: After either fatal result, `start` is ignored until reset: no fetch, no scan, no `done`. Both fatal flags hold their values.
- R13: During and right after reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin evaluating one page |
| pg_sel | input | 2 | Page size code |
| buf_num | input | $clog2(SECTORS) | Buffer number of the page |
| evt_status | input | 32 | Controller event status |
| stat_rd | output | 1 | Status word fetch strobe |
| word_addr | output | $clog2(SECTORS)-2 | Status word index |
| word_data | input | 32 | Status word, same cycle |
| byte_valid | input | 1 | Page byte present |
| byte_data | input | 8 | Page byte |
| byte_ready | output | 1 | Blank scan accepting bytes |
| done | output | 1 | Evaluation finished |
| res_good | output | 1 | Page correctable |
| res_blank | output | 1 | Page erased |
| res_ecc | output | 1 | Uncorrectable, not erased |
| res_timeout | output | 1 | Flash timeout seen |
| ecc_fatal | output | 1 | Sticky ECC failure |
| timeout_fatal | output | 1 | Sticky timeout failure |
| evt_clr_we | output | 1 | Event clear write strobe |
| evt_clr_val | output | 32 | Event bits to clear |

## Verification
The blank scan's end-of-page condition and its dirty-byte condition can fall in the same cycle when the only non-0xFF byte is the last one of the page. Operation-complete and timeout can also arrive in the same event sample. The bench provokes both. It places the bad byte at index 2047 of a 2048-byte page, and it raises both event bits together after a delay. The cycle-by-cycle reference model then expects the fatal result, and not blank or good, in the predicted cycle, with no event clear.

// File: rtl/ecc_eval_pkg.sv
package ecc_eval_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_FETCH,
        ST_SCAN,
        ST_HALT
    } ev_state_e;

    typedef struct packed {
        logic good;
        logic blank;
        logic ecc;
        logic tout;
    } ev_result_t;

    localparam int          LANES_PER_WORD = 4;
    localparam int          MAX_SPP        = 8;
    localparam logic [3:0]  CNT_UNCORR     = 4'hF;
    localparam logic [7:0]  ERASED_BYTE    = 8'hFF;

    function automatic logic [3:0] sectors_per_page(input logic [1:0] sel);
        case (sel)
            2'b01:   return 4'd4;
            2'b10:   return 4'd8;
            default: return 4'd1;
        endcase
    endfunction

    // slot 0 is the most significant byte of the word
    function automatic logic [3:0] lane_count(input logic [31:0] w, input logic [1:0] slot);
        logic [4:0] base;
        base = {~slot, 3'b000};
        return w[base +: 4];
    endfunction

endpackage

// File: rtl/ecc_sector_range.sv
module ecc_sector_range
    import ecc_eval_pkg::*;
#(
    parameter int SECTORS      = 16,
    parameter int SECTOR_BYTES = 512,
    localparam int SECT_W      = $clog2(SECTORS),
    localparam int WORD_W      = SECT_W - 2,
    localparam int PB_W        = $clog2(MAX_SPP * SECTOR_BYTES)
) (
    input  logic [1:0]        pg_sel,
    input  logic [SECT_W-1:0] buf_num,
    output logic [SECT_W-1:0] first_sec,
    output logic [SECT_W-1:0] last_sec,
    output logic [WORD_W-1:0] first_word,
    output logic [WORD_W-1:0] last_word,
    output logic [PB_W-1:0]   last_byte
);
    logic [3:0] spp;

    always_comb begin
        spp        = sectors_per_page(pg_sel);
        first_sec  = SECT_W'(buf_num * SECT_W'(spp));
        last_sec   = first_sec + SECT_W'(spp - 4'd1);
        first_word = first_sec[SECT_W-1:2];
        last_word  = last_sec[SECT_W-1:2];
        last_byte  = PB_W'(int'(spp) * SECTOR_BYTES - 1);
    end
endmodule

// File: rtl/ecc_word_scan.sv
module ecc_word_scan
    import ecc_eval_pkg::*;
#(
    parameter int SECTORS = 16,
    localparam int SECT_W = $clog2(SECTORS),
    localparam int WORD_W = SECT_W - 2
) (
    input  logic [31:0]       word,
    input  logic [WORD_W-1:0] widx,
    input  logic [SECT_W-1:0] first_sec,
    input  logic [SECT_W-1:0] last_sec,
    output logic              hit
);
    logic [LANES_PER_WORD-1:0] lane_hit;

    for (genvar s = 0; s < LANES_PER_WORD; s++) begin : g_lane
        logic [SECT_W-1:0] sec;
        logic              in_range;
        assign sec      = {widx, 2'(s)};
        assign in_range = (sec >= first_sec) && (sec <= last_sec);
        assign lane_hit[s] = in_range && (lane_count(word, 2'(s)) == CNT_UNCORR);
    end

    assign hit = |lane_hit;
endmodule

// File: rtl/ecc_blank_scan.sv
module ecc_blank_scan
    import ecc_eval_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    localparam int PB_W        = $clog2(MAX_SPP * SECTOR_BYTES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            active,
    input  logic [PB_W-1:0] last_byte,
    input  logic            byte_valid,
    input  logic [7:0]      byte_data,
    output logic            byte_ready,
    output logic            dirty,
    output logic            all_erased
);
    logic [PB_W-1:0] cnt;
    logic            take;

    assign byte_ready = active;
    assign take       = active && byte_valid;
    assign dirty      = take && (byte_data != ERASED_BYTE);
    assign all_erased = take && (byte_data == ERASED_BYTE) && (cnt == last_byte);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt <= '0;
        end else if (take) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R9
    scan_stops_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_ready && byte_valid && byte_data != ERASED_BYTE) |=> !byte_ready);
endmodule

// File: rtl/ecc_sector_eval.sv
module ecc_sector_eval
    import ecc_eval_pkg::*;
#(
    parameter int SECTORS      = 16,
    parameter int SECTOR_BYTES = 512,
    parameter int OPC_BIT      = 0,
    parameter int TOUT_BIT     = 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [1:0]                   pg_sel,
    input  logic [$clog2(SECTORS)-1:0]   buf_num,
    input  logic [31:0]                  evt_status,
    output logic                         stat_rd,
    output logic [$clog2(SECTORS)-3:0]   word_addr,
    input  logic [31:0]                  word_data,
    input  logic                         byte_valid,
    input  logic [7:0]                   byte_data,
    output logic                         byte_ready,
    output logic                         done,
    output logic                         res_good,
    output logic                         res_blank,
    output logic                         res_ecc,
    output logic                         res_timeout,
    output logic                         ecc_fatal,
    output logic                         timeout_fatal,
    output logic                         evt_clr_we,
    output logic [31:0]                  evt_clr_val
);
    localparam int SECT_W = $clog2(SECTORS);
    localparam int WORD_W = SECT_W - 2;
    localparam int PB_W   = $clog2(MAX_SPP * SECTOR_BYTES);

    ev_state_e         state;
    logic [1:0]        pg_q;
    logic [SECT_W-1:0] buf_q;
    logic [WORD_W-1:0] cur_word;
    logic [31:0]       evt_q;
    logic              done_q;
    ev_result_t        res_q;
    logic              clr_q;
    logic              ecc_st;
    logic              tout_st;

    logic [SECT_W-1:0] first_sec, last_sec;
    logic [WORD_W-1:0] first_word, last_word;
    logic [PB_W-1:0]   last_byte;
    logic              word_hit;
    logic              scan_dirty, scan_erased;

    ecc_sector_range #(.SECTORS(SECTORS), .SECTOR_BYTES(SECTOR_BYTES)) u_range (
        .pg_sel     (pg_q),
        .buf_num    (buf_q),
        .first_sec  (first_sec),
        .last_sec   (last_sec),
        .first_word (first_word),
        .last_word  (last_word),
        .last_byte  (last_byte)
    );

    ecc_word_scan #(.SECTORS(SECTORS)) u_word (
        .word      (word_data),
        .widx      (cur_word),
        .first_sec (first_sec),
        .last_sec  (last_sec),
        .hit       (word_hit)
    );

    ecc_blank_scan #(.SECTOR_BYTES(SECTOR_BYTES)) u_blank (
        .clk        (clk),
        .rst        (rst),
        .active     (state == ST_SCAN),
        .last_byte  (last_byte),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .byte_ready (byte_ready),
        .dirty      (scan_dirty),
        .all_erased (scan_erased)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            pg_q     <= '0;
            buf_q    <= '0;
            cur_word <= '0;
            evt_q    <= '0;
            done_q   <= 1'b0;
            res_q    <= '0;
            clr_q    <= 1'b0;
            ecc_st   <= 1'b0;
            tout_st  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            res_q  <= '0;
            clr_q  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        pg_q  <= pg_sel;
                        buf_q <= buf_num;
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (evt_status[OPC_BIT]) begin
                        evt_q <= evt_status;
                        if (evt_status[TOUT_BIT]) begin
                            tout_st    <= 1'b1;
                            done_q     <= 1'b1;
                            res_q.tout <= 1'b1;
                            state      <= ST_HALT;
                        end else begin
                            cur_word <= first_word;
                            state    <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: begin
                    if (word_hit) begin
                        state <= ST_SCAN;
                    end else if (cur_word == last_word) begin
                        done_q     <= 1'b1;
                        res_q.good <= 1'b1;
                        clr_q      <= 1'b1;
                        state      <= ST_IDLE;
                    end else begin
                        cur_word <= cur_word + 1'b1;
                    end
                end
                ST_SCAN: begin
                    if (scan_dirty) begin
                        ecc_st    <= 1'b1;
                        done_q    <= 1'b1;
                        res_q.ecc <= 1'b1;
                        state     <= ST_HALT;
                    end else if (scan_erased) begin
                        done_q      <= 1'b1;
                        res_q.blank <= 1'b1;
                        clr_q       <= 1'b1;
                        state       <= ST_IDLE;
                    end
                end
                ST_HALT: state <= ST_HALT;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign stat_rd       = (state == ST_FETCH);
    assign word_addr     = cur_word;
    assign done          = done_q;
    assign res_good      = res_q.good;
    assign res_blank     = res_q.blank;
    assign res_ecc       = res_q.ecc;
    assign res_timeout   = res_q.tout;
    assign ecc_fatal     = ecc_st;
    assign timeout_fatal = tout_st;
    assign evt_clr_we    = clr_q;
    assign evt_clr_val   = evt_q;

    // R11
    one_result_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $countones({res_good, res_blank, res_ecc, res_timeout}) == 1);

    // R11
    flag_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
        (res_good || res_blank || res_ecc || res_timeout) |-> done);

    // R9
    ecc_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ecc_fatal |=> ecc_fatal);

    // R6
    tout_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        timeout_fatal |=> timeout_fatal);

    // R10
    clear_on_pass_chk: assert property (@(posedge clk) disable iff (rst)
        evt_clr_we |-> (done && (res_good || res_blank)));

    // R4
    fetch_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        stat_rd |-> (word_addr >= first_word && word_addr <= last_word));

    // R12
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ecc_fatal || timeout_fatal) |-> (!stat_rd && !byte_ready));
endmodule

// File: tb/tb_ecc_sector_eval.sv
module tb_ecc_sector_eval;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  pg_sel = 2'b00;
    logic [3:0]  buf_num = 4'd0;
    logic [31:0] evt_status;
    logic        stat_rd;
    logic [1:0]  word_addr;
    logic [31:0] word_data;
    logic        byte_valid;
    logic [7:0]  byte_data;
    logic        byte_ready;
    logic        done, res_good, res_blank, res_ecc, res_timeout;
    logic        ecc_fatal, timeout_fatal, evt_clr_we;
    logic [31:0] evt_clr_val;

    logic [31:0] words [4];
    int          cyc = 0;
    int          bcnt = 0;
    int          total = 0;
    int          checks = 0;
    int          failures = 0;

    // case parameters and model predictions
    int          opc_at, vstart, bad_idx;
    logic [31:0] evt_val;
    bit          run = 0, x_none = 0, x_tout = 0, x_hit = 0;
    int          x_d, x_fw, x_edge, x_rd_last, x_scan_at, x_kind;
    bit          x_ecc_st = 0, x_tout_st = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_sector_eval dut (
        .clk(clk), .rst(rst), .start(start), .pg_sel(pg_sel), .buf_num(buf_num),
        .evt_status(evt_status), .stat_rd(stat_rd), .word_addr(word_addr),
        .word_data(word_data), .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_ready(byte_ready), .done(done), .res_good(res_good),
        .res_blank(res_blank), .res_ecc(res_ecc), .res_timeout(res_timeout),
        .ecc_fatal(ecc_fatal), .timeout_fatal(timeout_fatal),
        .evt_clr_we(evt_clr_we), .evt_clr_val(evt_clr_val)
    );

    assign word_data  = words[word_addr];
    assign evt_status = (cyc >= opc_at) ? evt_val : 32'h0;
    assign byte_valid = (cyc >= vstart);
    assign byte_data  = (bcnt == bad_idx) ? 8'h00 : 8'hFF;

    always @(posedge clk) begin
        total <= total + 1;
        cyc   <= start ? 0 : cyc + 1;
        if (start) bcnt <= 0;
        else if (byte_valid && byte_ready) bcnt <= bcnt + 1;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // kinds: 0 good, 1 blank, 2 ecc, 3 timeout
    always @(negedge clk) begin
        if (run) begin
            int  c;
            bit  exp_rd, exp_rdy;
            c = cyc;
            exp_rd  = !x_none && !x_tout && c >= 1 + x_d && c <= x_rd_last;
            exp_rdy = !x_none && x_hit && c >= x_scan_at && c < x_edge;
            chk(stat_rd == exp_rd, "R4 stat_rd", stat_rd, exp_rd);
            if (exp_rd)
                chk(word_addr == 2'(x_fw + c - 1 - x_d), "R4 word_addr", word_addr, x_fw + c - 1 - x_d);
            chk(byte_ready == exp_rdy, "R8 byte_ready", byte_ready, exp_rdy);
            if (!x_none && c == x_edge) begin
                if (x_kind == 2) x_ecc_st = 1;
                if (x_kind == 3) x_tout_st = 1;
                chk(done == 1'b1, "R11 done", done, 1);
                chk({res_good, res_blank, res_ecc, res_timeout} ==
                    4'(8 >> x_kind), "R7 R8 R9 R6 result", {res_good, res_blank, res_ecc, res_timeout}, 8 >> x_kind);
                chk(evt_clr_we == (x_kind < 2), "R10 clear strobe", evt_clr_we, x_kind < 2);
                if (x_kind < 2)
                    chk(evt_clr_val == evt_val, "R10 clear value", evt_clr_val, evt_val);
                run = 0;
            end else begin
                chk(done == 1'b0 && evt_clr_we == 1'b0, "R11 R12 idle done", {done, evt_clr_we}, 0);
            end
            chk(ecc_fatal == x_ecc_st, "R9 R12 ecc_fatal", ecc_fatal, x_ecc_st);
            chk(timeout_fatal == x_tout_st, "R6 R12 timeout_fatal", timeout_fatal, x_tout_st);
        end
    end

    task automatic pulse_start(input int pg, input int bn);
        @(negedge clk);
        pg_sel  = 2'(pg);
        buf_num = 4'(bn);
        start   = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
    endtask

    task automatic run_case(input int pg, input int bn, input int oat, input int vst,
                            input int bad, input logic [31:0] ev);
        int spp, first, last, fw, lw, nw, k, bytes;
        spp   = (pg == 1) ? 4 : (pg == 2) ? 8 : 1;
        first = (bn * spp) % 16;
        last  = first + spp - 1;
        fw = first / 4; lw = last / 4; nw = lw - fw + 1;
        k = -1;
        for (int w = fw; w <= lw && k < 0; w++)
            for (int s = 0; s < 4; s++) begin
                int sec;
                sec = w * 4 + s;
                if (k < 0 && sec >= first && sec <= last && ((words[w] >> (24 - 8 * s)) & 15) == 15)
                    k = w - fw;
            end
        opc_at = oat; vstart = vst; bad_idx = bad; evt_val = ev;
        x_none = 0; x_d = oat; x_fw = fw;
        x_tout = ev[1]; x_hit = !x_tout && (k >= 0);
        bytes = spp * 512;
        if (x_tout) begin
            x_kind = 3; x_edge = 1 + x_d; x_rd_last = -1; x_scan_at = 1 << 30;
        end else if (!x_hit) begin
            x_kind = 0; x_edge = 1 + x_d + nw; x_rd_last = x_d + nw; x_scan_at = 1 << 30;
        end else begin
            int base;
            x_scan_at = 2 + x_d + k;
            x_rd_last = 1 + x_d + k;
            base = (x_scan_at > vst) ? x_scan_at : vst;
            if (bad >= 0 && bad < bytes) begin
                x_kind = 2; x_edge = base + bad + 1;
            end else begin
                x_kind = 1; x_edge = base + bytes;
            end
        end
        pulse_start(pg, bn);
        run = 1;
        wait (run == 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic run_ignored();
        opc_at = 0; vstart = 0; bad_idx = 5; evt_val = 32'h1;
        x_none = 1;
        pulse_start(1, 0);
        run = 1;
        repeat (20) @(negedge clk);
        run = 0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk({done, res_good, res_blank, res_ecc, res_timeout, ecc_fatal, timeout_fatal,
             evt_clr_we, stat_rd, byte_ready} == 10'b0, "R13 in reset",
            {done, res_good, res_blank, res_ecc, res_timeout, ecc_fatal, timeout_fatal,
             evt_clr_we, stat_rd, byte_ready}, 0);
        rst = 1'b0;
        x_ecc_st = 0; x_tout_st = 0;
        @(negedge clk);
        chk({done, ecc_fatal, timeout_fatal, evt_clr_we, stat_rd, byte_ready} == 6'b0,
            "R13 after reset", {done, ecc_fatal, timeout_fatal, evt_clr_we, stat_rd, byte_ready}, 0);
    endtask

    initial begin
        opc_at = 0; vstart = 0; bad_idx = -1; evt_val = 32'h0;
        foreach (words[i]) words[i] = 32'h0;
        do_reset();

        // R1 R7: 512-byte page, sector 3, all counts zero
        run_case(0, 3, 0, 0, -1, 32'h1);
        // R2 R3: sectors 4..7 correctable, poison outside range
        words[0] = 32'hFFFF_FFFF; words[1] = 32'h0E0D_0C0B;
        words[2] = 32'hFFFF_FFFF; words[3] = 32'hFFFF_FFFF;
        run_case(1, 1, 0, 0, -1, 32'h1);
        // R3: high nibble 0xF ignored
        words[2] = 32'hF0F1_F2F3;
        run_case(1, 2, 0, 0, -1, 32'h1);
        // R8 R4 R10: 4096 page, sector 15 uncorrectable, erased page
        words[2] = 32'h0000_0000; words[3] = 32'h0000_000F;
        run_case(2, 1, 0, 0, -1, 32'h0000_0101);
        // R5 R10: delayed operation complete with extra event bits
        words[0] = 32'h0;
        run_case(0, 0, 5, 0, -1, 32'h0000_8001);
        // R8: sector 0 uncorrectable, byte stream starts late
        words[0] = 32'h0F00_0000;
        run_case(0, 0, 0, 20, -1, 32'h1);
        // R1: code 2'b11 is a 512-byte page, sector 7 clean though sector 6 is not
        words[1] = 32'h0000_0F00;
        run_case(3, 7, 0, 0, -1, 32'h1);
        // R9: dirty byte is the very last byte of a 2048 page
        words[0] = 32'h0000_0F00;
        run_case(1, 0, 0, 0, 2047, 32'h1);
        // R12: start ignored after ECC fatal
        run_ignored();

        do_reset();
        // R9: early dirty byte, uncorrectable sector 5 among out-of-range lanes
        words[1] = 32'h0F0F_0F0F;
        run_case(0, 5, 0, 0, 100, 32'h1);
        do_reset();
        // R6: timeout together with operation complete, after a delay
        run_case(1, 0, 2, 0, -1, 32'h0000_0003);
        // R12: start ignored after timeout fatal
        run_ignored();
        do_reset();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (total > 150000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", total);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule